// File: doc/BRIEF.md
# Column-Sliced Multi-Operand Compressor Array

The block adds many single-bit operands of mixed weight in one pass. Each column of weight 2^i has its own slice. A slice counts the bits of its column with a 15-input counter. It then re-reduces the counts with a 4-input counter and a 3-input counter, and closes with one bit of a ripple-carry adder. Counter results of higher weight leave a slice only through fixed links to the one to three slices above it. There is no general routing network between counters, so the wiring is identical for every input pattern.

Each slice has a two-bit rank code held in flip-flops. The codes are loaded through a serial shift chain. A full-rank slice uses all counter levels. Lower ranks switch off the leading counter levels and feed the slice's own input bits straight into the later ones. This trades column height for shorter logic depth.

The reduction datapath is combinational. The final word is registered once at the output.

Top module: `colslice_compressor`

## Requirements
- R1: While `rst` is high at a rising edge, `sum_q` becomes 0 and every rank code becomes 2'b00. This reset applies from the next cycle on.
- R2: At each rising edge with `cfg_load` high, the configuration word shifts up by one bit and takes `cfg_din` into bit 0. The word keeps its value when `cfg_load` is low. Slice i uses bits [2i+1:2i] of the word.
- R3: Rank code 2'b00 and 2'b11 both select full rank. Code 2'b10 selects the middle rank. Code 2'b01 selects the lowest rank.
- R4: In a full-rank slice i, input bits 0 to 14 of column i each add 2^i to the result. Column i is `col_bits[16*i +: 16]`.
- R5: A middle-rank slice i adds only input bits 0 to 3 of its column, each at weight 2^i. It discards the 15:4 counter bits that lower slices send to it.
- R6: A lowest-rank slice i adds only input bits 0 to 2 of its column. It discards both 15:4 and 4:3 counter bits that lower slices send to it.
- R7: Bit 15 of column 0 adds 1 to the result as the adder carry-in, in every rank. Bit 15 of every other column has no effect.
- R8: `sum_q` shows the result of the `col_bits` and configuration present just before a rising edge. It does so from that edge on, so the latency is one cycle.
- R9: When the admitted total is below 2^(NSLICE+1), `sum_q` equals that total exactly. The top bit of `sum_q` collects every link that reaches weight 2^NSLICE or above.
- R10: All-zero `col_bits` give `sum_q` = 0 one cycle later, whatever the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Shift enable of the rank configuration chain |
| cfg_din | input | 1 | Serial configuration bit entering bit 0 |
| col_bits | input | NSLICE*16 | Operand bits, 16 per column, column i at [16*i +: 16] |
| sum_q | output | NSLICE+1 | Registered sum; top bit holds weight 2^NSLICE |

## Verification
The hardest cases to reach are those where counter links land on the top weight column or cross a rank boundary. There, slices 5 to 7 send 15:4 or 4:3 bits past the last adder stage, or a lower-rank slice drops links from a full-rank neighbour. Random columns alone almost always overflow nine bits. The bench therefore generates dense and sparse patterns and clears whole upper columns until the admitted total fits. It then adds hand-built vectors whose totals are exactly 256 and 511. The configurations include uniform ranks, both full-rank codes and random per-slice mixes, so that dropped links across rank boundaries occur often.

// File: rtl/ccmp_pkg.sv
package ccmp_pkg;
  localparam int COL_H    = 16;  // input bits per column
  localparam int CODE_W   = 2;   // rank code width per slice
  localparam logic [CODE_W-1:0] CODE_FULL  = 2'b00;
  localparam logic [CODE_W-1:0] CODE_LOW   = 2'b01;
  localparam logic [CODE_W-1:0] CODE_MID   = 2'b10;
  localparam logic [CODE_W-1:0] CODE_FULL2 = 2'b11;

  function automatic logic is_full(input logic [CODE_W-1:0] code);
    return (code == CODE_FULL) || (code == CODE_FULL2);
  endfunction
endpackage

// File: rtl/ccmp_cfg_chain.sv
module ccmp_cfg_chain #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (shift_en) begin
      word_q <= {word_q[W-2:0], din};
    end
  end
endmodule

// File: rtl/ccmp_popcnt.sv
module ccmp_popcnt #(
  parameter int N = 15,
  localparam int W = $clog2(N + 1)
) (
  input  logic [N-1:0] bits_i,
  output logic [W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int k = 0; k < N; k++) begin
      cnt_o = cnt_o + W'(bits_i[k]);
    end
  end
endmodule

// File: rtl/ccmp_slice.sv
module ccmp_slice
  import ccmp_pkg::*;
(
  input  logic [COL_H-2:0]  col_i,    // bits 0..14 of this column
  input  logic [CODE_W-1:0] code_i,
  input  logic [2:0]        l15_i,    // [k] = 15:4 bit k+1 from slice i-k-1
  output logic [2:0]        l15_o,    // [k] = 15:4 bit k+1 towards slice i+k+1
  input  logic [1:0]        l43_i,    // [k] = 4:3 bit k+1 from slice i-k-1
  output logic [1:0]        l43_o,
  input  logic              c32_i,    // 3:2 carry from slice i-1
  output logic              c32_o,
  input  logic              rip_i,
  output logic              rip_o,
  output logic              sum_o
);
  logic       full, mid, low;
  logic [14:0] op15;
  logic [3:0] c15;
  logic [3:0] op43;
  logic [2:0] c43;
  logic [2:0] op32;
  logic [1:0] c32;

  assign full = is_full(code_i);
  assign mid  = (code_i == CODE_MID);
  assign low  = (code_i == CODE_LOW);

  // level 1: 15:4 counter, idle below full rank
  assign op15 = full ? col_i : '0;
  ccmp_popcnt #(.N(15)) u_c15 (.bits_i(op15), .cnt_o(c15));

  // level 2: 4:3 counter, fed by links or by own bits in middle rank
  always_comb begin
    op43 = '0;
    if (full)     op43 = {l15_i, c15[0]};
    else if (mid) op43 = col_i[3:0];
  end
  ccmp_popcnt #(.N(4)) u_c43 (.bits_i(op43), .cnt_o(c43));

  // level 3: 3:2 counter, own bits in lowest rank
  assign op32 = low ? col_i[2:0] : {l43_i, c43[0]};
  ccmp_popcnt #(.N(3)) u_c32 (.bits_i(op32), .cnt_o(c32));

  assign l15_o = c15[3:1];
  assign l43_o = c43[2:1];
  assign c32_o = c32[1];

  // level 4: one bit of the ripple adder
  assign {rip_o, sum_o} = 2'(c32[0]) + 2'(c32_i) + 2'(rip_i);
endmodule

// File: rtl/colslice_compressor.sv
module colslice_compressor
  import ccmp_pkg::*;
#(
  parameter int NSLICE = 8,
  localparam int NB    = NSLICE * COL_H,
  localparam int CFG_W = NSLICE * CODE_W,
  localparam int OUT_W = NSLICE + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_load,
  input  logic             cfg_din,
  input  logic [NB-1:0]    col_bits,
  output logic [OUT_W-1:0] sum_q
);
  logic [CFG_W-1:0]  cfg_word;
  logic [2:0]        l15    [NSLICE];
  logic [2:0]        l15_in [NSLICE];
  logic [1:0]        l43    [NSLICE];
  logic [1:0]        l43_in [NSLICE];
  logic [NSLICE-1:0] c32, rip, sbit, top_bits;
  logic              ovf;
  logic              unused_top;

  ccmp_cfg_chain #(.W(CFG_W)) u_cfg (
    .clk(clk), .rst(rst), .shift_en(cfg_load), .din(cfg_din), .word_q(cfg_word)
  );

  for (genvar j = 0; j < NSLICE; j++) begin : g_slice
    assign top_bits[j] = col_bits[j*COL_H + COL_H - 1];

    for (genvar k = 0; k < 3; k++) begin : g_l15
      if (j - k - 1 >= 0) begin : g_on
        assign l15_in[j][k] = l15[j-k-1][k];
      end else begin : g_off
        assign l15_in[j][k] = 1'b0;
      end
    end
    for (genvar k = 0; k < 2; k++) begin : g_l43
      if (j - k - 1 >= 0) begin : g_on
        assign l43_in[j][k] = l43[j-k-1][k];
      end else begin : g_off
        assign l43_in[j][k] = 1'b0;
      end
    end

    logic c32_in, rip_in;
    if (j == 0) begin : g_first
      assign c32_in = 1'b0;
      assign rip_in = top_bits[0];  // column 0 bit 15 is the carry-in
    end else begin : g_rest
      assign c32_in = c32[j-1];
      assign rip_in = rip[j-1];
    end

    ccmp_slice u_slice (
      .col_i (col_bits[j*COL_H +: COL_H-1]),
      .code_i(cfg_word[j*CODE_W +: CODE_W]),
      .l15_i (l15_in[j]),
      .l15_o (l15[j]),
      .l43_i (l43_in[j]),
      .l43_o (l43[j]),
      .c32_i (c32_in),
      .c32_o (c32[j]),
      .rip_i (rip_in),
      .rip_o (rip[j]),
      .sum_o (sbit[j])
    );
  end

  assign unused_top = ^top_bits[NSLICE-1:1];

  // every link that lands on or past the top weight merges into one bit
  always_comb begin
    ovf = c32[NSLICE-1] | rip[NSLICE-1];
    for (int i = 0; i < NSLICE; i++) begin
      for (int k = 0; k < 3; k++) begin
        if (i + k + 1 >= NSLICE) ovf = ovf | l15[i][k];
      end
      for (int k = 0; k < 2; k++) begin
        if (i + k + 1 >= NSLICE) ovf = ovf | l43[i][k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sum_q <= '0;
    else     sum_q <= {ovf, sbit};
  end
endmodule

// File: rtl/colslice_compressor_chk.sv
module colslice_compressor_chk #(
  parameter int NSLICE = 8,
  localparam int NB    = NSLICE * 16,
  localparam int CFG_W = NSLICE * 2,
  localparam int OUT_W = NSLICE + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_load,
  input logic             cfg_din,
  input logic [NB-1:0]    col_bits,
  input logic [OUT_W-1:0] sum_q,
  input logic [CFG_W-1:0] cfg_word
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (sum_q == '0 && cfg_word == '0));

  p_cfg_shift_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> cfg_word == {$past(cfg_word[CFG_W-2:0]), $past(cfg_din)});

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !cfg_load |=> $stable(cfg_word));

  p_zero_in_r10: assert property (@(posedge clk) disable iff (rst)
    (col_bits == '0) |=> (sum_q == '0));

  p_steady_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cfg_load) && $stable(col_bits)) |=> $stable(sum_q));
endmodule

bind colslice_compressor colslice_compressor_chk #(.NSLICE(NSLICE)) u_chk (
  .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_din(cfg_din),
  .col_bits(col_bits), .sum_q(sum_q), .cfg_word(cfg_word)
);

// File: tb/test_colslice_compressor.sv
`timescale 1ns/1ps
module test_colslice_compressor;
  localparam int NS    = 8;
  localparam int NB    = NS * 16;
  localparam int CW    = NS * 2;
  localparam int OW    = NS + 1;
  localparam int LIMIT = 1 << OW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_load = 1'b0;
  logic          cfg_din = 1'b0;
  logic [NB-1:0] col_bits = '0;
  logic [OW-1:0] sum_q;

  int n_cmp = 0;
  int n_bad = 0;
  logic [CW-1:0] model_cfg = '0;
  int    exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  colslice_compressor #(.NSLICE(NS)) i_colslice_compressor (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_din(cfg_din),
    .col_bits(col_bits), .sum_q(sum_q)
  );

  function automatic int code_of(input logic [CW-1:0] cw, input int i);
    return int'(cw[2*i +: 2]);
  endfunction

  // admitted weighted total from the requirements (R3..R7, R9)
  function automatic int ref_sum(input logic [NB-1:0] cb, input logic [CW-1:0] cw);
    int c15[NS];
    int v43[NS];
    int tot;
    int code;
    tot = int'(cb[15]);  // R7: carry-in
    for (int i = 0; i < NS; i++) begin
      code = code_of(cw, i);
      c15[i] = (code == 0 || code == 3) ? $countones(cb[16*i +: 15]) : 0;
    end
    for (int i = 0; i < NS; i++)
      for (int k = 1; k < 4; k++)
        if (i + k >= NS) tot += ((c15[i] >> k) & 1) << (i + k);
    for (int j = 0; j < NS; j++) begin
      code = code_of(cw, j);
      v43[j] = 0;
      if (code == 0 || code == 3) begin
        for (int k = 0; k < 4; k++)
          if (j - k >= 0) v43[j] += (c15[j-k] >> k) & 1;
      end else if (code == 2) begin
        v43[j] = $countones(cb[16*j +: 4]);
      end
    end
    for (int i = 0; i < NS; i++)
      for (int k = 1; k < 3; k++)
        if (i + k >= NS) tot += ((v43[i] >> k) & 1) << (i + k);
    for (int j = 0; j < NS; j++) begin
      int v32;
      code = code_of(cw, j);
      v32 = 0;
      if (code == 1) v32 = $countones(cb[16*j +: 3]);
      else
        for (int k = 0; k < 3; k++)
          if (j - k >= 0) v32 += (v43[j-k] >> k) & 1;
      tot += v32 << j;
    end
    return tot;
  endfunction

  // one clock: check the previous result, then drive new inputs
  task automatic step(input logic [NB-1:0] cb, input logic ld, input logic din,
                      input string tag);
    int e;
    string t;
    @(negedge clk);
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (e >= 0) begin
        n_cmp++;
        if (int'(sum_q) != e) begin
          n_bad++;
          $display("FAIL %s: sum_q=%0d expected=%0d", t, sum_q, e);
        end
      end
    end
    col_bits = cb;
    cfg_load = ld;
    cfg_din  = din;
    e = ref_sum(cb, model_cfg);
    exp_q.push_back(e < LIMIT ? e : -1);
    tag_q.push_back(tag);
    if (ld) model_cfg = {model_cfg[CW-2:0], din};
  endtask

  task automatic load_cfg(input logic [CW-1:0] w);
    for (int b = CW - 1; b >= 0; b--) step('0, 1'b1, w[b], "R2/R10 load");
  endtask

  function automatic logic [NB-1:0] gen(input int dens);
    logic [NB-1:0] cb;
    for (int i = 0; i < NS; i++) begin
      logic [15:0] v;
      v = 16'($urandom);
      for (int d = 0; d < dens; d++) v = v & 16'($urandom);
      cb[16*i +: 16] = v;
    end
    for (int j = NS - 1; j >= 0; j--)
      if (ref_sum(cb, model_cfg) >= LIMIT) cb[16*j +: 16] = '0;
    return cb;
  endfunction

  task automatic run_random(input int n, input string tag);
    for (int r = 0; r < n; r++) step(gen(r % 4), 1'b0, 1'b0, tag);
  endtask

  function automatic logic [CW-1:0] uniform(input logic [1:0] c);
    logic [CW-1:0] w;
    for (int i = 0; i < NS; i++) w[2*i +: 2] = c;
    return w;
  endfunction

  bit done = 1'b0;
  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [NB-1:0] cb;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    n_cmp++;
    if (sum_q != '0) begin
      n_bad++;
      $display("FAIL R1: sum_q=%0d expected=0", sum_q);
    end

    // R4/R9/R8: full rank straight from reset (code 00)
    run_random(40, "R4/R9 full rank after reset");
    step('0, 1'b0, 1'b0, "R10 zero input");

    // R9 boundaries: 256 through the top links, 511 the largest fit
    cb = '0; cb[16*7 +: 2] = 2'b11;
    step(cb, 1'b0, 1'b0, "R9 total 256");
    cb = '0; cb[16*7 +: 3] = 3'b111;
    for (int i = 0; i < 7; i++) cb[16*i + 5] = 1'b1;
    step(cb, 1'b0, 1'b0, "R9 total 511");
    cb = '0; cb[16*5 +: 8] = 8'hff;
    step(cb, 1'b0, 1'b0, "R9 column 5 height 8");

    // R7: bit 15 roles
    cb = '0; cb[15] = 1'b1;
    step(cb, 1'b0, 1'b0, "R7 carry-in only");
    for (int i = 1; i < NS; i++) begin
      cb = '0; cb[16*i + 15] = 1'b1; cb[0] = 1'b1;
      step(cb, 1'b0, 1'b0, "R7 upper bit 15 ignored");
    end

    // R5: middle rank, upper bits present but ignored
    load_cfg(uniform(2'b10));
    run_random(40, "R5/R3 middle rank");
    cb = '1;
    step(cb, 1'b0, 1'b0, "R5 all ones middle rank");

    // R6: lowest rank
    load_cfg(uniform(2'b01));
    run_random(40, "R6/R3 lowest rank");
    step('1, 1'b0, 1'b0, "R6 all ones lowest rank");

    // R3: second full-rank code
    load_cfg(uniform(2'b11));
    run_random(40, "R3 code 11 full rank");

    // R5/R6/R2: mixed per-slice ranks, links cross rank boundaries
    for (int m = 0; m < 6; m++) begin
      load_cfg(CW'($urandom));
      run_random(30, "R2/R5/R6 mixed ranks");
      step('0, 1'b0, 1'b0, "R10 zero after mix");
    end

    // R8: result follows a configuration change one cycle later
    load_cfg(uniform(2'b00));
    cb = '0; cb[16*2 +: 15] = '1;
    step(cb, 1'b0, 1'b0, "R8 full rank column 2");
    step(cb, 1'b1, 1'b0, "R8 input held while shifting");
    step(cb, 1'b0, 1'b0, "R8 after shift");

    // R1: reset clears output
    step('1, 1'b0, 1'b0, "R1 pre-reset");
    @(negedge clk);
    rst = 1'b1;
    void'(exp_q.pop_front());
    void'(tag_q.pop_front());
    @(negedge clk);
    rst = 1'b0;
    model_cfg = '0;
    n_cmp++;
    if (sum_q != '0) begin
      n_bad++;
      $display("FAIL R1: sum_q=%0d expected=0 after reset", sum_q);
    end
    cb = '0; cb[16*1 +: 15] = '1;
    step(cb, 1'b0, 1'b0, "R1 config back to full rank");
    step('0, 1'b0, 1'b0, "R10 final flush");
    step('0, 1'b0, 1'b0, "R10 final flush");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule